// File: doc/BRIEF.md
# Receive Buffer with Frequency-Coded Flow Control

This block sits on the receive side of a serial link and runs in the clock of the link's parallel word interface, for example 125 MHz for a 2.5 Gbit/s link. Incoming 16-bit words enter a synchronous first-in first-out buffer. Downstream logic takes them out through a second stream port. The buffer reports its level, full and empty flags, and a sticky overflow flag.

A single-bit line carries flow control back to the sender. It never rests at a fixed level, so it stays DC-free on an AC-coupled pair. Its frequency carries the state. When the line toggles every cycle, the wave is at half the clock rate and the sender may keep sending. When the line holds for four cycles high and then four cycles low, the wave is at one eighth of the clock rate and the sender must stop.

Stop signalling starts once the free space falls to a programmable threshold. The default of 18 free words covers the forward and return latency of the link. A hysteresis band of 2 words keeps the mode steady near that point. Both stream ports use valid/ready handshakes. The write side applies back-pressure by dropping `in_ready` while the buffer is full. The read side offers the head word whenever the buffer is not empty.

Top module: `rx_fc_fifo`

## Requirements
- R1: While reset is high and on the cycle after it, `level`=0, `empty`=1, `full`=0, `overflow`=0 and `fc_line`=0; the wave starts in ready mode.
- R2: `in_ready` equals not `full`. A word is stored when `in_valid` and `in_ready` are both high at a rising edge, and `level` then rises by one unless a read happens in the same cycle.
- R3: Words leave in the order they were accepted. `out_valid` is high when the buffer is not empty, and `out_data` is the oldest word. A word is removed when `out_valid` and `out_ready` are both high at a rising edge.
- R4: A write attempted while the buffer is full is dropped and leaves the stored data unchanged. It sets `overflow`, which then stays at 1 until reset.
- R5: A read attempted while the buffer is empty has no effect. `level` stays 0 and `out_valid` stays 0.
- R6: In ready mode, `fc_line` inverts on every clock cycle.
- R7: In stop mode, `fc_line` alternates runs of exactly 4 cycles high and 4 cycles low. Stop mode is requested when the free space (DEPTH − `level`) is at or below STOP_FREE (default 18). The request takes effect at the next run boundary.
- R8: Once the block is in stop mode, it returns to ready mode only when the free space exceeds STOP_FREE + HYST (default 20). Free space of 19 or 20 keeps the current mode.
- R9: The mode changes only at a run boundary. No run of `fc_line` is shorter than one cycle or longer than 4 cycles.
- R10: `full` is 1 exactly when `level` = DEPTH, and `empty` is 1 exactly when `level` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-interface clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Link side offers a word |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | 16 | Incoming word |
| out_valid | output | 1 | Head word available |
| out_ready | input | 1 | Downstream takes the head word |
| out_data | output | 16 | Head word |
| level | output | 7 | Number of stored words |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| overflow | output | 1 | Sticky: a write was attempted while full |
| fc_line | output | 1 | Square-wave flow-control line to the sender |

## Verification
The hardest behaviour to reach from the ports is the hysteresis band. A free space of 19 or 20 words must give either wave, depending on the direction from which the level arrived. The bench fills the buffer one word at a time and measures the run lengths of `fc_line` at every level. It then drains the buffer one word at a time and measures again. Each level is therefore visited on both the rising and the falling path, and the band appears as a different expected mode at the same level.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef enum logic { FC_READY = 1'b0, FC_STOP = 1'b1 } fc_mode_t;
endpackage

// File: rtl/rxfc_store.sv
module rxfc_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_try,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_try,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fill,
  output logic              is_full,
  output logic              is_empty,
  output logic              ovf
);
  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              wr_go, rd_go;

  assign is_full  = (fill == LVL_W'(DEPTH));
  assign is_empty = (fill == '0);
  assign wr_go    = wr_try && !is_full;
  assign rd_go    = rd_try && !is_empty;
  assign rd_data  = slots[rp];

  always_ff @(posedge clk) begin
    if (wr_go) slots[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
      ovf  <= 1'b0;
    end else begin
      if (wr_go) wp <= wp + 1'b1;
      if (rd_go) rp <= rp + 1'b1;
      case ({wr_go, rd_go})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (wr_try && is_full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rxfc_mode_ctrl.sv
module rxfc_mode_ctrl
  import rxfc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int STOP_FREE = 18,
  parameter int HYST      = 2,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fill,
  output fc_mode_t         want
);
  logic [LVL_W-1:0] free_cnt;
  assign free_cnt = LVL_W'(DEPTH) - fill;

  always_ff @(posedge clk) begin
    if (rst)                                        want <= FC_READY;
    else if (free_cnt <= LVL_W'(STOP_FREE))         want <= FC_STOP;
    else if (free_cnt > LVL_W'(STOP_FREE + HYST))   want <= FC_READY;
  end
endmodule

// File: rtl/rxfc_wave_gen.sv
module rxfc_wave_gen
  import rxfc_pkg::*;
#(
  parameter int STOP_HALF = 4,
  localparam int CNT_W    = $clog2(STOP_HALF + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  fc_mode_t want,
  output logic     line
);
  fc_mode_t         cur;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = (cur == FC_STOP) ? CNT_W'(STOP_HALF - 1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= FC_READY;
      cnt  <= '0;
      line <= 1'b0;
    end else if (cnt == last) begin
      line <= !line;
      cnt  <= '0;
      cur  <= want;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_fc_fifo.sv
module rx_fc_fifo
  import rxfc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 64,
  parameter int STOP_FREE = 18,
  parameter int HYST      = 2,
  parameter int STOP_HALF = 4,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              fc_line
);
  fc_mode_t want;

  rxfc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .wr_try(in_valid), .wr_data(in_data),
    .rd_try(out_ready), .rd_data(out_data),
    .fill(level), .is_full(full), .is_empty(empty), .ovf(overflow)
  );

  rxfc_mode_ctrl #(.DEPTH(DEPTH), .STOP_FREE(STOP_FREE), .HYST(HYST)) u_mode (
    .clk(clk), .rst(rst), .fill(level), .want(want)
  );

  rxfc_wave_gen #(.STOP_HALF(STOP_HALF)) u_wave (
    .clk(clk), .rst(rst), .want(want), .line(fc_line)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
endmodule

// File: rtl/rx_fc_fifo_chk.sv
module rx_fc_fifo_chk #(
  parameter int DEPTH     = 64,
  parameter int STOP_HALF = 4,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_ready,
  input logic             out_valid,
  input logic [LVL_W-1:0] level,
  input logic             full,
  input logic             empty,
  input logic             overflow,
  input logic             fc_line
);
  logic prev_line;
  int   run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_line <= 1'b0;
      run_cnt   <= 0;
    end else begin
      prev_line <= fc_line;
      run_cnt   <= (fc_line == prev_line) ? run_cnt + 1 : 0;
    end
  end

  // R10
  a_r10_full_level: assert property (@(posedge clk) disable iff (rst)
    full |-> (level == LVL_W'(DEPTH)));
  // R10
  a_r10_empty_level: assert property (@(posedge clk) disable iff (rst)
    empty |-> (level == '0));
  // R2
  a_r2_level_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (level == $past(level)) || (level == $past(level) + 1'b1) ||
             (level + 1'b1 == $past(level)));
  // R4
  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R4
  a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full && !out_ready) |=> (full && overflow));
  // R5
  a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
    (empty && !in_valid && out_ready) |=> (empty && !out_valid));
  // R9
  a_r9_run_bound: assert property (@(posedge clk) disable iff (rst)
    run_cnt < STOP_HALF);
endmodule

bind rx_fc_fifo rx_fc_fifo_chk #(.DEPTH(DEPTH), .STOP_HALF(STOP_HALF)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
  .out_valid(out_valid), .level(level), .full(full), .empty(empty),
  .overflow(overflow), .fc_line(fc_line)
);

// File: tb/rx_fc_fifo_test.sv
module rx_fc_fifo_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, out_valid, full, empty, overflow, fc_line;
  logic [15:0] out_data;
  logic [6:0]  level;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = !clk;

  rx_fc_fifo uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .level(level), .full(full), .empty(empty),
    .overflow(overflow), .fc_line(fc_line)
  );

  function automatic logic [15:0] word_of(int k);
    return 16'(k * 16'h0137 + 16'h5A03);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(string req, int exp_len);
    logic cur;
    int len;
    for (int w = 0; w < 12; w++) @(negedge clk);
    cur = fc_line;
    len = 0;
    while (fc_line == cur && len < 20) begin len++; @(negedge clk); end
    for (int r = 0; r < 3; r++) begin
      cur = fc_line;
      len = 0;
      while (fc_line == cur && len < 20) begin len++; @(negedge clk); end
      chk(req, len, exp_len);
    end
  endtask

  task automatic push(int k);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = word_of(k);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(int k);
    @(negedge clk);
    chk("R3 data", int'(out_data), int'(word_of(k)));
    chk("R3 valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 level", int'(level), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 fc_line", int'(fc_line), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 line after reset", int'(fc_line), 1);
    chk("R1 level after reset", int'(level), 0);
    measure("R6 ready wave", 1);

    // rising sweep
    for (int n = 1; n <= DEPTH; n++) begin
      push(n - 1);
      chk("R2 level", int'(level), n);
      chk("R2 in_ready", int'(in_ready), (n < DEPTH) ? 1 : 0);
      chk("R10 full", int'(full), (n == DEPTH) ? 1 : 0);
      chk("R10 empty", int'(empty), 0);
      if (n >= 40) measure((DEPTH - n <= 18) ? "R7 stop wave" : "R8 rising ready",
                           (DEPTH - n <= 18) ? 4 : 1);
    end

    // overflow
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'hFFFF;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 overflow set", int'(overflow), 1);
    chk("R4 level held", int'(level), DEPTH);
    repeat (3) @(negedge clk);
    chk("R4 overflow sticky", int'(overflow), 1);

    // draining sweep
    for (int n = DEPTH - 1; n >= 0; n--) begin
      pop(DEPTH - 1 - n);
      chk("R3 level", int'(level), n);
      chk("R10 empty", int'(empty), (n == 0) ? 1 : 0);
      chk("R10 full", int'(full), 0);
      if (n >= 38) measure((DEPTH - n <= 20) ? "R8 hysteresis stop" : "R8 return ready",
                           (DEPTH - n <= 20) ? 4 : 1);
    end

    // empty read
    @(negedge clk);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    chk("R5 level", int'(level), 0);
    chk("R5 out_valid", int'(out_valid), 0);
    push(200);
    chk("R5 level after push", int'(level), 1);
    chk("R5 head word", int'(out_data), int'(word_of(200)));
    chk("R4 still sticky", int'(overflow), 1);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R4 cleared by reset", int'(overflow), 0);
    chk("R1 empty after reset", int'(empty), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule